// File: doc/BRIEF.md
# Programmable Frame Pulse Generator

This block produces the framing pulse for one group of a time-division multiplexed link. It runs on a master clock of 2048 cycles per 125 µs frame. A free-running frame counter marks the position in the frame. Two byte-wide configuration registers set where the pulse sits in the frame, how wide it is, which polarity it has, and which data rate sets the length of its bit cell.

Software writes the registers at any time. The block holds each write in a shadow copy and moves it into the working configuration only when the frame counter wraps. A pulse that has started always runs to its full length with the level it started with, even when it crosses into a frame that has a new configuration. A system with several groups uses one instance per group.

Top module: `frame_pulse_gen`

## Requirements
- R1: While `rst` is high, and after it is released, every configuration field is zero and `fp_o` is high. `fp_o` stays high for the whole first frame.
- R2: The 11-bit offset is built from two fields. Bits 10:8 come from mode-register bits 2:0 (`wr_addr`=1). Bits 7:0 come from the start register (`wr_addr`=0). The frame position is the number of clock edges since reset was released, modulo 2048. A pulse of W cycles is active at frame positions offset+1 through offset+W.
- R3: The mode field is mode-register bits 7:6. Value 2 gives an active-low pulse on a high idle line. Value 3 gives an active-high pulse on a low idle line.
- R4: Mode values 0 and 1 start no pulse, and `fp_o` stays high.
- R5: Mode-register bit 5 selects the pulse width: 0 gives one bit cell and 1 gives eight bit cells. Bits 4:3 select the bit-cell length: 0 gives 8 cycles (2 Mb/s), 1 gives 4 cycles (4 Mb/s) and 2 gives 2 cycles (8 Mb/s).
- R6: Rate code 3 starts no pulse, and `fp_o` holds the idle level of the mode (low for mode 3).
- R7: A register write changes nothing in the frame in which it occurs. The written value applies from the next frame boundary on.
- R8: A pulse that runs past the end of a frame keeps its full width and level, even when the next frame's configuration disables the output.
- R9: With an unchanged configuration, the pulse repeats every 2048 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 2048 cycles per frame |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the start register, 1 the mode register |
| wr_data | input | 8 | Write data |
| fp_o | output | 1 | Frame pulse output |

## Verification
The bench builds the block with its package defaults: an 11-bit offset and a 2048-cycle frame. Thirteen full frames therefore fit easily in the run, and the bench compares every cycle of each frame with the expected level. This covers the widest pulse (64 cycles), the narrowest (2 cycles), an offset at the very end of the frame that wraps into the next frame, and writes that land in the middle of a frame.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int OFF_W   = 11;
  localparam int FRAME_N = 1 << OFF_W;
  localparam int REG_W   = 8;
  localparam int LEN_W   = 7;

  typedef struct packed {
    logic [1:0]       mode;
    logic             wide;
    logic [1:0]       rate;
    logic [OFF_W-1:0] off;
  } fpg_cfg_t;

  // master cycles in one bit cell
  function automatic logic [LEN_W-1:0] cell_cycles(input logic [1:0] rate);
    logic [LEN_W-1:0] c;
    c = LEN_W'(8) >> rate;
    return c;
  endfunction

  function automatic logic [LEN_W-1:0] pulse_cycles(input logic [1:0] rate, input logic wide);
    return wide ? (cell_cycles(rate) << 3) : cell_cycles(rate);
  endfunction

  function automatic logic cfg_enabled(input fpg_cfg_t c);
    return c.mode[1] && (c.rate != 2'd3);
  endfunction

  // low idle only for inverted framing
  function automatic logic idle_level(input logic [1:0] mode);
    return mode != 2'd3;
  endfunction
endpackage

// File: rtl/fpg_counter.sv
module fpg_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             frame_wrap
);
  localparam logic [CNT_W-1:0] LAST = '1;

  assign frame_wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    frame_wrap |=> (cnt == '0));
  assert_step_R9: assert property (@(posedge clk) disable iff (rst)
    !frame_wrap |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/fpg_regs.sv
module fpg_regs
  import fpg_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          frame_wrap,
  output fpg_cfg_t      act
);
  logic [DW-1:0] start_sh, mode_sh;
  fpg_cfg_t      pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_sh <= '0;
      mode_sh  <= '0;
    end else if (wr_en) begin
      if (wr_addr) mode_sh  <= wr_data;
      else         start_sh <= wr_data;
    end
  end

  // unpack the mode byte: [7:6] mode, [5] width, [4:3] rate, [2:0] offset high
  always_comb begin
    pend.mode = mode_sh[7:6];
    pend.wide = mode_sh[5];
    pend.rate = mode_sh[4:3];
    pend.off  = {mode_sh[OFF_W-DW-1:0], start_sh};
  end

  always_ff @(posedge clk) begin
    if (rst)             act <= '0;
    else if (frame_wrap) act <= pend;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !frame_wrap |=> $stable(act));
endmodule

// File: rtl/fpg_shaper.sv
module fpg_shaper
  import fpg_pkg::*;
#(
  parameter int CNT_W = OFF_W,
  parameter int LW    = LEN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  fpg_cfg_t         act,
  output logic             pulse_on,
  output logic             fp_o
);
  logic          start;
  logic [LW-1:0] rem_q, w_q, run_len;
  logic          lvl_q;

  assign start    = cfg_enabled(act) && (cnt == act.off);
  assign pulse_on = (rem_q != '0);
  assign fp_o     = pulse_on ? lvl_q : idle_level(act.mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      w_q   <= '0;
      lvl_q <= 1'b0;
    end else if (start) begin
      rem_q <= pulse_cycles(act.rate, act.wide);
      w_q   <= pulse_cycles(act.rate, act.wide);
      lvl_q <= !idle_level(act.mode);
    end else if (pulse_on) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  // checker-side length counter
  always_ff @(posedge clk) begin
    if (rst)           run_len <= '0;
    else if (start)    run_len <= '0;
    else if (pulse_on) run_len <= run_len + 1'b1;
  end

  assert_width_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_on) |-> (run_len == w_q));
endmodule

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen
  import fpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic             fp_o
);
  logic [OFF_W-1:0] cnt;
  logic             frame_wrap;
  logic             pulse_on;
  fpg_cfg_t         act;

  fpg_counter #(.CNT_W(OFF_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt(cnt), .frame_wrap(frame_wrap)
  );

  fpg_regs #(.DW(REG_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_wrap(frame_wrap), .act(act)
  );

  fpg_shaper #(.CNT_W(OFF_W), .LW(LEN_W)) u_shp (
    .clk(clk), .rst(rst), .cnt(cnt), .act(act),
    .pulse_on(pulse_on), .fp_o(fp_o)
  );

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> fp_o);
  assert_level_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_on) |-> (fp_o == ($past(act.mode) == 2'd3)));
  assert_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_enabled(act)) && !$past(pulse_on)) |-> !pulse_on);
endmodule

// File: tb/frame_pulse_gen_tb.sv
module frame_pulse_gen_tb;
  localparam int FR = 2048;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       fp_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frame_pulse_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fp_o(fp_o)
  );

  // Called at a negedge where the frame position is 0; returns at the next one.
  // Pulse expected at positions off+1..off+w when en; level is !idle.
  task automatic scan(input string req, input int off, input int w, input bit en,
                      input bit idle, input bit do_wr, input int wr_c,
                      input logic [7:0] s_v, input logic [7:0] m_v);
    int  bad_c = -1;
    bit  bad_v = 1'b0, bad_e = 1'b0;
    for (int c = 0; c < FR; c++) begin
      bit exp_v;
      exp_v = (en && c >= off + 1 && c <= off + w) ? !idle : idle;
      if (fp_o !== exp_v && bad_c < 0) begin
        bad_c = c; bad_v = fp_o; bad_e = exp_v;
      end
      wr_en = 1'b0;
      if (do_wr && c == wr_c)     begin wr_en = 1'b1; wr_addr = 1'b0; wr_data = s_v; end
      if (do_wr && c == wr_c + 1) begin wr_en = 1'b1; wr_addr = 1'b1; wr_data = m_v; end
      @(negedge clk);
    end
    wr_en = 1'b0;
    n_chk++;
    if (bad_c >= 0) begin
      n_fail++;
      $display("FAIL %s: frame position %0d actual %0b expected %0b", req, bad_c, bad_v, bad_e);
    end
  endtask

  task automatic t_reset();
    n_chk++;
    if (fp_o !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: fp_o during reset actual %0b expected 1", fp_o);
    end
    @(negedge clk); rst = 1'b0;
    // R1: first frame idle high; load config A (off 0x123, normal, 1 cell, 2 Mb/s)
    scan("R1", 0, 0, 1'b0, 1'b1, 1'b1, 1000, 8'h23, 8'h81);
  endtask

  task automatic t_normal();
    // R2 R3 (normal): W=8; next: off 5, inverted, 8 cells, 4 Mb/s
    scan("R2", 'h123, 8, 1'b1, 1'b1, 1'b1, 1000, 8'h05, 8'hE8);
  endtask

  task automatic t_inverted();
    // R3 inverted, R5 W=32; next: off 0x7E0, 8 cells, 8 Mb/s
    scan("R3", 5, 32, 1'b1, 1'b0, 1'b1, 1000, 8'hE0, 8'hB7);
  endtask

  task automatic t_widths();
    // R5 W=16; next: off 700, 1 cell, 8 Mb/s
    scan("R5", 'h7E0, 16, 1'b1, 1'b1, 1'b1, 1000, 8'hBC, 8'h92);
    // R5 W=2; next: mode 1
    scan("R5", 700, 2, 1'b1, 1'b1, 1'b1, 1000, 8'hBC, 8'h42);
  endtask

  task automatic t_disabled();
    // R4 mode 1 idle high; next: mode 3 with rate 3
    scan("R4", 700, 2, 1'b0, 1'b1, 1'b1, 1000, 8'hBC, 8'hDA);
    // R6 reserved rate, inverted idle low; next: off 100 normal W=8
    scan("R6", 700, 2, 1'b0, 1'b0, 1'b1, 1000, 8'h64, 8'h80);
  endtask

  task automatic t_deferred();
    // R7: write off 200 at position 150, current frame keeps off 100
    scan("R7", 100, 8, 1'b1, 1'b1, 1'b1, 150, 8'hC8, 8'h80);
    // R7: new offset applies; next: off 2040, 8 cells, 2 Mb/s (W=64)
    scan("R7", 200, 8, 1'b1, 1'b1, 1'b1, 1000, 8'hF8, 8'hA7);
  endtask

  task automatic t_wrap();
    // R8: pulse starts at 2041, runs into the next frame; disable next frame
    scan("R8", 2040, 64, 1'b1, 1'b1, 1'b1, 100, 8'h00, 8'h00);
    // R8: remaining 57 cycles low at positions 0..56, then idle; reload config A
    scan("R8", -1, 57, 1'b1, 1'b1, 1'b1, 100, 8'h23, 8'h81);
  endtask

  task automatic t_period();
    // R9: same pulse in consecutive frames
    scan("R9", 'h123, 8, 1'b1, 1'b1, 1'b0, 0, 8'h00, 8'h00);
    scan("R9", 'h123, 8, 1'b1, 1'b1, 1'b0, 0, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_normal();
    t_inverted();
    t_widths();
    t_disabled();
    t_deferred();
    t_wrap();
    t_period();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (60000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run incomplete actual timeout expected finish");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule